// File: doc/BRIEF.md
# Odd-Parity Serial Receiver with Read Handshake

This block receives frames from one asynchronous serial line on a local clock that has no relation to the sender's clock. The line passes through a two-flop synchronizer. While the receiver is idle, a low level on the synchronized line starts a frame. Each bit period lasts `CLK_HZ / BAUD_HZ` clocks, and the receiver samples each bit at the middle count of its period. A frame is one start bit, `DATA_W` data bits sent least significant first, one odd-parity bit and one stop bit.

When a word passes the parity check, the receiver holds it and raises `rd_ready`. A reader collects the word by driving `rd_req` high. There is no back-pressure on the line side. While a word is held, the line is not watched, so any frame that arrives during the hold is lost. A word that fails the parity check is discarded with no output activity.

Top module: `serial_rx_odd`

## Requirements
- R1: After reset, `rd_ready` and `rd_valid` are 0 and `rd_data` is all zeros.
- R2: A frame starts when the synchronized line is low while idle. Each bit lasts `CLK_HZ/BAUD_HZ` clocks and is sampled at count `(CLK_HZ/BAUD_HZ-1)/2` of its period.
- R3: The first data bit after the start bit lands in `rd_data[0]` and the last lands in `rd_data[DATA_W-1]`.
- R4: A word is accepted only when the parity bit equals the inverse of the XOR of all data bits (odd parity).
- R5: A word that fails parity produces no `rd_ready` and no `rd_valid`, and the receiver returns to idle.
- R6: After an accepted frame, `rd_ready` rises within two bit periods of the stop bit's start. It then stays high until `rd_req` is seen.
- R7: When `rd_req` is high while `rd_ready` is high at a clock edge, `rd_valid` is high for exactly the next cycle and `rd_ready` falls in that same cycle. `rd_ready` and `rd_valid` are never both high.
- R8: `rd_data` holds its value from the rise of `rd_ready` through the end of the `rd_valid` pulse.
- R9: Frames that arrive while a word is held are ignored, and the held word is delivered unchanged.
- R10: After the `rd_valid` pulse the receiver returns to idle and accepts the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Asynchronous serial line, idle high |
| rd_req | input | 1 | Reader request to collect the held word |
| rd_ready | output | 1 | A checked word is waiting |
| rd_data | output | DATA_W | Received word, LSB = first data bit |
| rd_valid | output | 1 | One-cycle pulse that marks a transfer of `rd_data` |

## Verification
The bench builds the block with `DATA_W = 8`, `CLK_HZ = 16 MHz` and `BAUD_HZ = 1 MHz`, so each bit lasts 16 clocks and is sampled at count 7. An 8-bit word makes the all-zeros, all-ones, single-LSB and single-MSB patterns short to drive, which exposes bit-order and parity-polarity errors. The short bit period also leaves room to hold a word for many bit times while a second complete frame is sent on the line.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_HOLD = 2'd2
  } srx_state_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= 1'b1;
        else if (g == 0) chain[g] <= d_in;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/srx_timing.sv
module srx_timing #(
  parameter int OS    = 16,
  parameter int NBITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic [$clog2(NBITS+3)-1:0] bit_idx,
  output logic at_mid,
  output logic at_last
);
  localparam int CW = $clog2(OS);
  localparam int BW = $clog2(NBITS+3);
  localparam logic [CW-1:0] MID_C  = CW'((OS-1)/2);
  localparam logic [CW-1:0] LAST_C = CW'(OS-1);

  logic [CW-1:0] tick_q;
  logic [BW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= '0;
      idx_q  <= '0;
    end else if (start) begin
      tick_q <= CW'(1);
      idx_q  <= '0;
    end else if (run) begin
      if (tick_q == LAST_C) begin
        tick_q <= '0;
        idx_q  <= idx_q + BW'(1);
      end else begin
        tick_q <= tick_q + CW'(1);
      end
    end
  end

  assign bit_idx = idx_q;
  assign at_mid  = run && (tick_q == MID_C);
  assign at_last = run && (tick_q == LAST_C);
endmodule

// File: rtl/srx_shift.sv
module srx_shift #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  input  logic             data_en,
  input  logic             par_en,
  output logic [NBITS-1:0] word,
  output logic             parity_ok
);
  logic [NBITS-1:0] word_q;
  logic             par_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      par_q  <= 1'b0;
    end else begin
      if (data_en) word_q <= {bit_in, word_q[NBITS-1:1]};
      if (par_en)  par_q  <= bit_in;
    end
  end

  assign word      = word_q;
  assign parity_ok = (par_q == ~(^word_q));
endmodule

// File: rtl/serial_rx_odd.sv
module serial_rx_odd #(
  parameter int DATA_W  = 8,
  parameter int CLK_HZ  = 16_000_000,
  parameter int BAUD_HZ = 1_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic              rd_req,
  output logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  import srx_pkg::*;

  localparam int OS = CLK_HZ / BAUD_HZ;
  localparam int BW = $clog2(DATA_W+3);
  localparam logic [BW-1:0] PAR_IDX  = BW'(DATA_W+1);
  localparam logic [BW-1:0] STOP_IDX = BW'(DATA_W+2);
  localparam logic [BW-1:0] LAST_DAT = BW'(DATA_W);

  srx_state_e state_q, state_d;
  logic          line_s;
  logic [BW-1:0] bit_idx;
  logic          at_mid, at_last;
  logic          start, run, data_en, par_en, frame_end, parity_ok;

  srx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(line_in), .d_out(line_s)
  );

  assign start = (state_q == ST_IDLE) && !line_s;
  assign run   = (state_q == ST_RECV);

  srx_timing #(.OS(OS), .NBITS(DATA_W)) u_timing (
    .clk(clk), .rst_n(rst_n), .start(start), .run(run),
    .bit_idx(bit_idx), .at_mid(at_mid), .at_last(at_last)
  );

  assign data_en   = at_mid && (bit_idx != '0) && (bit_idx <= LAST_DAT);
  assign par_en    = at_mid && (bit_idx == PAR_IDX);
  assign frame_end = at_last && (bit_idx == STOP_IDX);

  srx_shift #(.NBITS(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_in(line_s), .data_en(data_en),
    .par_en(par_en), .word(rd_data), .parity_ok(parity_ok)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (!line_s) state_d = ST_RECV;
      ST_RECV: if (frame_end) state_d = parity_ok ? ST_HOLD : ST_IDLE;
      ST_HOLD: if (rd_valid) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      rd_ready <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      state_q  <= state_d;
      rd_valid <= 1'b0;
      if (frame_end && parity_ok) begin
        rd_ready <= 1'b1;
      end else if (state_q == ST_HOLD && rd_ready && rd_req) begin
        rd_ready <= 1'b0;
        rd_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_rx_odd_chk.sv
module serial_rx_odd_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid
);
  // R6
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready && !rd_req |=> rd_ready);
  // R7
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  // R7
  valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(rd_ready && rd_req));
  // R7
  ready_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_ready && rd_valid));
  // R8
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |=> $stable(rd_data));
endmodule

bind serial_rx_odd serial_rx_odd_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ready(rd_ready),
  .rd_data(rd_data), .rd_valid(rd_valid)
);

// File: tb/serial_rx_odd_bench.sv
module serial_rx_odd_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int OS = 16;
  localparam int NV = 7;
  // {accept, flip parity, data}
  localparam logic [9:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h00}, {1'b1, 1'b0, 8'hFF}, {1'b1, 1'b0, 8'hA5},
    {1'b1, 1'b0, 8'h01}, {1'b1, 1'b0, 8'h80}, {1'b0, 1'b1, 8'h3C},
    {1'b0, 1'b1, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_in = 1'b1;
  logic rd_req = 1'b0;
  logic rd_ready, rd_valid;
  logic [W-1:0] rd_data;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rx_odd #(.DATA_W(W), .CLK_HZ(16_000_000), .BAUD_HZ(1_000_000)) u_serial_rx_odd (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .rd_req(rd_req),
    .rd_ready(rd_ready), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] d, input bit flip);
    logic par;
    par = ~(^d) ^ flip;
    @(negedge clk) line_in = 1'b0;
    repeat (OS) @(negedge clk);
    for (int i = 0; i < W; i++) begin
      line_in = d[i];
      repeat (OS) @(negedge clk);
    end
    line_in = par;
    repeat (OS) @(negedge clk);
    line_in = 1'b1;
    repeat (OS) @(negedge clk);
  endtask

  task automatic wait_ready(output bit got);
    got = 1'b0;
    for (int i = 0; i < 2*OS; i++) begin
      if (rd_ready) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic collect(input logic [W-1:0] exp, input string tag);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk(rd_valid === 1'b1 && rd_ready === 1'b0, {tag, " R7 valid pulse"}, {rd_valid, rd_ready}, 2);
    chk(rd_data === exp, {tag, " R3 R4 data"}, rd_data, exp);
    @(negedge clk);
    chk(rd_valid === 1'b0, {tag, " R7 single cycle"}, rd_valid, 0);
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit got;
    repeat (3) @(negedge clk);
    chk(rd_ready === 0 && rd_valid === 0 && rd_data === '0, "R1 reset", {rd_ready, rd_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rd_ready === 0 && rd_valid === 0, "R1 after release", {rd_ready, rd_valid}, 0);

    // R2 R10: table walk, back-to-back frames
    for (int v = 0; v < NV; v++) begin
      send(VEC[v][7:0], VEC[v][8]);
      wait_ready(got);
      if (VEC[v][9]) begin
        chk(got, "R6 ready after accepted frame", got, 1);
        if (got) begin
          repeat (5) @(negedge clk);
          chk(rd_ready === 1'b1, "R6 ready held without request", rd_ready, 1);
          collect(VEC[v][7:0], "R10 table");
        end
      end else begin
        chk(!got && rd_valid === 1'b0, "R5 bad parity dropped", got, 0);
      end
    end

    // R9: frame during hold is ignored
    send(8'h5A, 1'b0);
    wait_ready(got);
    chk(got, "R9 first word ready", got, 1);
    send(8'hC3, 1'b0);
    chk(rd_ready === 1'b1 && rd_data === 8'h5A, "R9 R8 held word unchanged", rd_data, 8'h5A);
    collect(8'h5A, "R9");

    // R10: receiver usable after hold
    send(8'h96, 1'b0);
    wait_ready(got);
    chk(got, "R10 next frame ready", got, 1);
    if (got) collect(8'h96, "R10");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule